// File: doc/BRIEF.md
# Configurable Stream Register Stage

This block sits on one valid/ready stream channel carrying a data word, an end-of-packet flag and a sideband user field. Its job is to cut the timing paths between the producer and the consumer. A single parameter picks how it does that. Mode 0 is a plain wire that adds no delay and no storage. Mode 1 is a one-entry slice that can pass a beat at most every other cycle. Mode 2 is a two-entry skid buffer that can pass a beat every cycle.

In both registered modes, the downstream valid and the upstream ready come straight from flip-flops. Neither port combines the other side's handshake signals combinationally.

The back-pressure rules are the usual ones for a valid/ready stream:
- A beat moves on any clock edge where valid and ready are both high.
- The producer keeps a presented beat unchanged until it is taken.
- The block keeps its own output beat unchanged while the consumer holds ready low.

Top module: `stream_stage`

## Requirements
- R1: With MODE=0, m_valid, m_data, m_last and m_user equal s_valid, s_data, s_last and s_user in the same cycle, and s_ready equals m_ready in the same cycle.
- R2: With MODE=1, a steady stream with valid and ready always high moves 10 beats in 20 cycles: one beat every two cycles.
- R3: With MODE=1, s_ready is high exactly when the output register holds no beat (s_ready == !m_valid after reset), and it is low in the cycle after any accepted beat.
- R4: With MODE=2, a steady stream with valid and ready always high moves 10 beats in 11 cycles: one cycle of latency, then one beat per cycle.
- R5: With MODE=2, a beat accepted while the output is stalled leaves the block after the beat that was already at the output and before any later beat.
- R6: With MODE=2, when a beat is accepted while m_valid is high and m_ready is low, s_ready is low in the next cycle. It rises again in the cycle after the output beat is taken.
- R7: In every mode, under any pattern of valid and ready stalls, the beats come out in the same order they went in. No beat is lost or duplicated, and each beat's data, last flag and user field stay together.
- R8: In modes 1 and 2, after reset m_valid is low and s_ready is high.
- R9: In modes 1 and 2, while m_valid is high and m_ready is low, m_valid stays high and m_data, m_last and m_user stay unchanged on the next cycle.
- R10: In modes 1 and 2, a beat accepted while the output is empty shows up on m_valid in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | DATA_W | Upstream data word |
| s_last | input | 1 | Upstream end-of-packet flag |
| s_user | input | USER_W | Upstream sideband field |
| s_valid | input | 1 | Upstream beat present |
| s_ready | output | 1 | Block can take an upstream beat |
| m_data | output | DATA_W | Downstream data word |
| m_last | output | 1 | Downstream end-of-packet flag |
| m_user | output | USER_W | Downstream sideband field |
| m_valid | output | 1 | Downstream beat present |
| m_ready | input | 1 | Consumer takes the downstream beat |

## Verification
The bench builds three copies of the block side by side, one with MODE set to each of 0, 1 and 2. All three use DATA_W=16 and USER_W=2, and they share the same input stimulus. Having all three copies lets every mode's handshake timing be checked in one run:
- the wire's same-cycle ready path;
- the slice's alternating ready;
- the skid register filling and draining.

The narrow user field still carries a distinct value per beat position, so any mixing between beats shows up in the ordering checks.

// File: rtl/stage_pkg.sv
package stage_pkg;
  localparam int MODE_WIRE = 0;
  localparam int MODE_HALF = 1;
  localparam int MODE_SKID = 2;

  function automatic bit mode_is_registered(int mode);
    return (mode == MODE_HALF) || (mode == MODE_SKID);
  endfunction
endpackage

// File: rtl/stage_wire.sv
module stage_wire #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] in_pl,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [PW-1:0] out_pl,
  output logic          out_valid,
  input  logic          out_ready
);
  // Pure pass-through: no storage, both directions combinational.
  assign out_pl    = in_pl;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/stage_half.sv
module stage_half #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] in_pl,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [PW-1:0] out_pl,
  output logic          out_valid,
  input  logic          out_ready
);
  logic [PW-1:0] hold_q;
  logic          full_q;
  logic          rdy_q;
  logic          take;
  logic          full_n;

  // A beat can only enter while the single register is empty, and the
  // ready flop only learns about emptiness one edge later.
  assign take   = in_valid & rdy_q;
  assign full_n = take | (full_q & ~out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      full_q <= full_n;
      rdy_q  <= ~full_n;
    end
  end

  always_ff @(posedge clk) begin
    if (take) hold_q <= in_pl;
  end

  assign in_ready  = rdy_q;
  assign out_valid = full_q;
  assign out_pl    = hold_q;
endmodule

// File: rtl/stage_skid.sv
module stage_skid #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] in_pl,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [PW-1:0] out_pl,
  output logic          out_valid,
  input  logic          out_ready
);
  logic [PW-1:0] head_q;
  logic [PW-1:0] spare_q;
  logic          head_v;
  logic          spare_v;
  logic          rdy_q;
  logic          take;
  logic          give;
  logic          head_vn;
  logic          spare_vn;
  logic          load_head_in;
  logic          load_head_spare;
  logic          load_spare;

  assign take = in_valid & rdy_q;
  assign give = head_v & out_ready;

  always_comb begin
    head_vn         = head_v;
    spare_vn        = spare_v;
    load_head_in    = 1'b0;
    load_head_spare = 1'b0;
    load_spare      = 1'b0;
    if (give) begin
      if (spare_v) begin
        // The older parked beat moves up before anything newer.
        load_head_spare = 1'b1;
        spare_vn        = 1'b0;
      end else begin
        head_vn = 1'b0;
      end
    end
    if (take) begin
      if (!head_v || give) begin
        load_head_in = 1'b1;
        head_vn      = 1'b1;
      end else begin
        load_spare = 1'b1;
        spare_vn   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_v  <= 1'b0;
      spare_v <= 1'b0;
      rdy_q   <= 1'b1;
    end else begin
      head_v  <= head_vn;
      spare_v <= spare_vn;
      rdy_q   <= ~spare_vn;
    end
  end

  always_ff @(posedge clk) begin
    if (load_head_spare)   head_q <= spare_q;
    else if (load_head_in) head_q <= in_pl;
    if (load_spare)        spare_q <= in_pl;
  end

  assign in_ready  = rdy_q;
  assign out_valid = head_v;
  assign out_pl    = head_q;
endmodule

// File: rtl/stream_stage.sv
module stream_stage #(
  parameter int DATA_W = 32,
  parameter int USER_W = 1,
  parameter int MODE   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic [USER_W-1:0] s_user,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic [USER_W-1:0] m_user,
  output logic              m_valid,
  input  logic              m_ready
);
  import stage_pkg::*;

  localparam int PW = DATA_W + USER_W + 1;

  logic [PW-1:0] in_pl;
  logic [PW-1:0] out_pl;

  assign in_pl = {s_user, s_last, s_data};
  assign {m_user, m_last, m_data} = out_pl;

  generate
    if (MODE == MODE_HALF) begin : g_half
      stage_half #(.PW(PW)) u_stage (
        .clk(clk), .rst(rst),
        .in_pl(in_pl), .in_valid(s_valid), .in_ready(s_ready),
        .out_pl(out_pl), .out_valid(m_valid), .out_ready(m_ready)
      );
    end else if (MODE == MODE_SKID) begin : g_skid
      stage_skid #(.PW(PW)) u_stage (
        .clk(clk), .rst(rst),
        .in_pl(in_pl), .in_valid(s_valid), .in_ready(s_ready),
        .out_pl(out_pl), .out_valid(m_valid), .out_ready(m_ready)
      );
    end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      stage_wire #(.PW(PW)) u_stage (
        .in_pl(in_pl), .in_valid(s_valid), .in_ready(s_ready),
        .out_pl(out_pl), .out_valid(m_valid), .out_ready(m_ready)
      );
    end
  endgenerate
endmodule

// File: rtl/stage_chk.sv
module stage_chk #(
  parameter int DATA_W = 32,
  parameter int USER_W = 1,
  parameter int MODE   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input logic [USER_W-1:0] m_user,
  input logic              m_valid,
  input logic              m_ready
);
  generate
    if (MODE == 1 || MODE == 2) begin : g_reg
      // R9
      hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_user)));
      // R10
      fill_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && !m_valid) |=> m_valid);
    end
    if (MODE == 1) begin : g_half
      // R3
      empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready == !m_valid);
      // R2
      half_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> !s_ready);
    end
    if (MODE == 2) begin : g_skid
      // R6
      skid_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && m_valid && !m_ready) |=> !s_ready);
    end
  endgenerate
endmodule

bind stream_stage stage_chk #(.DATA_W(DATA_W), .USER_W(USER_W), .MODE(MODE)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .m_data(m_data), .m_last(m_last), .m_user(m_user),
  .m_valid(m_valid), .m_ready(m_ready)
);

// File: tb/stream_stage_test.sv
module stream_stage_test;
  localparam int DW = 16;
  localparam int UW = 2;
  localparam int PW = DW + UW + 1;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [DW-1:0] s_data;
  logic s_last;
  logic [UW-1:0] s_user;
  logic s_valid;
  logic m_ready;

  wire [DW-1:0] d0, d1, d2;
  wire l0, l1, l2, v0, v1, v2, r0, r1, r2;
  wire [UW-1:0] u0, u1, u2;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  stream_stage #(.DATA_W(DW), .USER_W(UW), .MODE(0)) uut_m0 (
    .clk(clk), .rst(rst), .s_data(s_data), .s_last(s_last), .s_user(s_user),
    .s_valid(s_valid), .s_ready(r0), .m_data(d0), .m_last(l0), .m_user(u0),
    .m_valid(v0), .m_ready(m_ready));
  stream_stage #(.DATA_W(DW), .USER_W(UW), .MODE(1)) uut_m1 (
    .clk(clk), .rst(rst), .s_data(s_data), .s_last(s_last), .s_user(s_user),
    .s_valid(s_valid), .s_ready(r1), .m_data(d1), .m_last(l1), .m_user(u1),
    .m_valid(v1), .m_ready(m_ready));
  stream_stage #(.DATA_W(DW), .USER_W(UW), .MODE(2)) uut (
    .clk(clk), .rst(rst), .s_data(s_data), .s_last(s_last), .s_user(s_user),
    .s_valid(s_valid), .s_ready(r2), .m_data(d2), .m_last(l2), .m_user(u2),
    .m_valid(v2), .m_ready(m_ready));

  function automatic logic [PW-1:0] mk(int i);
    logic [DW-1:0] d = DW'(i * 37 + 5);
    logic l = (i % 4) == 3;
    logic [UW-1:0] u = UW'(i % 4);
    return {u, l, d};
  endfunction

  function automatic logic [PW-1:0] pl(int k);
    case (k)
      0: return {u0, l0, d0};
      1: return {u1, l1, d1};
      default: return {u2, l2, d2};
    endcase
  endfunction

  function automatic logic vld(int k);
    return (k == 0) ? v0 : (k == 1) ? v1 : v2;
  endfunction

  function automatic logic rdy(int k);
    return (k == 0) ? r0 : (k == 1) ? r1 : r2;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit v, int idx, bit r);
    @(negedge clk);
    s_valid = v;
    {s_user, s_last, s_data} = mk(idx);
    m_ready = r;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; m_ready = 1'b0;
    s_data = '0; s_last = 1'b0; s_user = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R8: reset state of the registered modes
  task automatic t_reset_state();
    do_reset();
    #1;
    chk(v1 == 1'b0, "R8", "mode1 m_valid", int'(v1), 0);
    chk(r1 == 1'b1, "R8", "mode1 s_ready", int'(r1), 1);
    chk(v2 == 1'b0, "R8", "mode2 m_valid", int'(v2), 0);
    chk(r2 == 1'b1, "R8", "mode2 s_ready", int'(r2), 1);
  endtask

  // R1: bypass is combinational in both directions
  task automatic t_wire_comb();
    do_reset();
    drive(1'b1, 7, 1'b0);
    chk(v0 == 1'b1, "R1", "m_valid follows s_valid", int'(v0), 1);
    chk(pl(0) == mk(7), "R1", "payload follows", int'(pl(0)), int'(mk(7)));
    chk(r0 == 1'b0, "R1", "s_ready follows low m_ready", int'(r0), 0);
    drive(1'b0, 8, 1'b1);
    chk(v0 == 1'b0, "R1", "m_valid low", int'(v0), 0);
    chk(r0 == 1'b1, "R1", "s_ready follows high m_ready", int'(r0), 1);
  endtask

  // R3, R9, R10: single slice under a stall
  task automatic t_half_stall();
    do_reset();
    drive(1'b1, 0, 1'b0);
    chk(r1 == 1'b1, "R3", "ready while empty", int'(r1), 1);
    drive(1'b1, 1, 1'b0);
    chk(v1 == 1'b1 && pl(1) == mk(0), "R10", "beat out next cycle", int'(pl(1)), int'(mk(0)));
    chk(r1 == 1'b0, "R3", "ready low while full", int'(r1), 0);
    drive(1'b1, 1, 1'b0);
    chk(pl(1) == mk(0) && v1, "R9", "held under stall", int'(pl(1)), int'(mk(0)));
    drive(1'b0, 1, 1'b1);
    chk(v1 == 1'b1, "R9", "still valid before take", int'(v1), 1);
    drive(1'b0, 1, 1'b0);
    chk(v1 == 1'b0 && r1 == 1'b1, "R3", "ready back when empty", int'(r1), 1);
  endtask

  // R5, R6, R9, R10: skid register fill and drain
  task automatic t_skid_fill();
    do_reset();
    drive(1'b1, 0, 1'b0);
    chk(r2 == 1'b1 && v2 == 1'b0, "R8", "idle before first beat", int'(r2), 1);
    drive(1'b1, 1, 1'b0);
    chk(v2 == 1'b1 && pl(2) == mk(0), "R10", "first beat out", int'(pl(2)), int'(mk(0)));
    chk(r2 == 1'b1, "R6", "still ready with skid empty", int'(r2), 1);
    drive(1'b1, 2, 1'b0);
    chk(r2 == 1'b0, "R6", "ready low after skid fill", int'(r2), 0);
    chk(pl(2) == mk(0), "R9", "head held", int'(pl(2)), int'(mk(0)));
    drive(1'b1, 2, 1'b1);
    chk(pl(2) == mk(0) && r2 == 1'b0, "R5", "older beat leaves first", int'(pl(2)), int'(mk(0)));
    drive(1'b0, 2, 1'b0);
    chk(v2 && pl(2) == mk(1), "R5", "parked beat next", int'(pl(2)), int'(mk(1)));
    chk(r2 == 1'b1, "R6", "ready back after drain", int'(r2), 1);
  endtask

  // R7 (plus R1/R2/R4 when exp_cyc >= 0): stream with stalls
  task automatic t_stream(int k, int n, int vp, int rp, string req, int exp_cyc);
    int sent = 0;
    int got = 0;
    int cyc = 0;
    bit take = 1'b0;
    do_reset();
    while (got < n && cyc < 4000) begin
      @(negedge clk);
      if (take) begin s_valid = 1'b0; take = 1'b0; end
      if (!s_valid && sent < n && $urandom_range(99) < vp) begin
        s_valid = 1'b1;
        {s_user, s_last, s_data} = mk(sent);
      end
      m_ready = ($urandom_range(99) < rp);
      #1;
      if (vld(k) && m_ready) begin
        chk(pl(k) == mk(got), req, $sformatf("mode%0d beat %0d", k, got), int'(pl(k)), int'(mk(got)));
        got++;
      end
      if (s_valid && rdy(k)) begin sent++; take = 1'b1; end
      cyc++;
    end
    @(negedge clk);
    s_valid = 1'b0; m_ready = 1'b0;
    chk(got == n, "R7", $sformatf("mode%0d beat count", k), got, n);
    if (exp_cyc >= 0)
      chk(cyc == exp_cyc, req, $sformatf("mode%0d cycles", k), cyc, exp_cyc);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R7: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; s_valid = 1'b0; m_ready = 1'b0;
    s_data = '0; s_last = 1'b0; s_user = '0;
    t_reset_state();
    t_wire_comb();
    t_half_stall();
    t_skid_fill();
    t_stream(0, 10, 100, 100, "R1", 10);
    t_stream(1, 10, 100, 100, "R2", 20);
    t_stream(2, 10, 100, 100, "R4", 11);
    t_stream(0, 40, 60, 60, "R7", -1);
    t_stream(1, 60, 70, 40, "R7", -1);
    t_stream(2, 60, 80, 30, "R7", -1);
    t_stream(2, 60, 40, 90, "R7", -1);
    t_stream(1, 40, 100, 100, "R7", -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule